// File: doc/BRIEF.md
# Gated Event Scaler Bank

This block is a bank of wide counting channels. A channel advances by one on each clock edge at which its gate condition is true. When its load condition is true it instead takes a preset value held in its own register. Each channel has two 16-bit control words, one for the gate and one for the load. A control word picks the condition from a small set: constantly true, one of four control lines shared by the whole bank, one of two control lines that belong to this channel alone, or the AND of two lines. The AND forms let one channel measure how often two separate sources fire together. Setting the load to a per-channel strobe with a zero preset, while the gate is always on, turns a channel into a counter of clock ticks since the last strobe.

A plain register port configures the channels and reads them out. A latch strobe copies every live counter into a snapshot register in the same cycle, so that a readout of all channels is coherent. Each counter wraps at 2^CNT_W and sets a sticky overflow flag. Software clears the flag with a write.

Top module: `gated_scaler_bank`

## Requirements
- R1: After synchronous reset, every register that the read port can reach reads zero: gate control, load control, preset, status and snapshot.
- R2: A control word with bit 15 clear never fires. A channel whose gate and load words both have bit 15 clear keeps its count while control lines toggle.
- R3: A gate word of 0x8000 (bit 15 set, code 0) is always true. The channel then counts one per clock edge.
- R4: Gate or load codes 1, 2, 3 and 4 (bits 3:0) select shared control lines 0, 1, 2 and 3. The count grows by the number of edges at which the selected line is high.
- R5: Code 9 selects shared line 0 AND shared line 1. Code 11 selects the channel's own line 0 AND its own line 1. Either one counts only coincident edges.
- R6: Code 8 selects the channel's own control line 0 and code 10 selects its own line 1. Channel i owns bits 2i and 2i+1 of ind_ctl. Lines owned by other channels have no effect.
- R7: A load word of 0x8008 loads the preset on each edge at which the channel's own line 0 is high. When load and gate fire on the same edge, the load wins.
- R8: A gate increment from the all-ones value wraps to zero and sets the channel's overflow flag (status bit 0). The flag stays set until a write to the status slot clears it. If a wrap and the clearing write fall on the same edge, the flag ends up set.
- R9: On an edge with latch high, each channel's snapshot takes that channel's count from before the edge. Snapshots hold their value while latch is low.
- R10: The address is {channel, slot}, with the slot in the low 3 bits. Slot 0 is gate control, 1 is load control, 2 is preset, 3 is status and 4 is snapshot. Control words and presets read back as written, and control words are zero-extended.
- R11: Codes 5 to 7 and 12 to 15 never fire, even with bit 15 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | CH_W+3 | Write address {channel, slot} |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | CH_W+3 | Read address {channel, slot} |
| rd_data | output | CNT_W | Read data for rd_addr (combinational) |
| shared_ctl | input | 4 | Control lines shared by all channels |
| ind_ctl | input | NUM_CH*2 | Per-channel control lines, two per channel |
| latch | input | 1 | Snapshot strobe for all channels |

## Verification
Several kinds of input pattern drive the counting function. An always-true gate tells counting on every edge apart from gated counting. Random activity on a single shared line checks that the source select picks the right line. Random shared and per-channel lines under the AND codes tell coincidence counting apart from a plain OR or a single line. Activity limited to a neighbour's per-channel lines shows that the lines stay private to their owner. Directed cases cover a load at the same time as a count, a wrap from near all-ones together with clearing the flag, and holding the snapshot while the counters move on. Random rounds with mixed codes, enables and presets then compare every channel against a model built from the requirements.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    localparam int CTL_W      = 16;
    localparam int NUM_SHARED = 4;
    localparam int NUM_IND    = 2;
    localparam int SLOT_W     = 3;

    typedef enum logic [3:0] {
        SRC_ALWAYS = 4'd0,
        SRC_SH0    = 4'd1,
        SRC_SH1    = 4'd2,
        SRC_SH2    = 4'd3,
        SRC_SH3    = 4'd4,
        SRC_IND0   = 4'd8,
        SRC_SH01   = 4'd9,
        SRC_IND1   = 4'd10,
        SRC_IND01  = 4'd11
    } src_code_e;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_GATE   = 3'd0,
        SLOT_LOAD   = 3'd1,
        SLOT_PRESET = 3'd2,
        SLOT_STATUS = 3'd3,
        SLOT_SNAP   = 3'd4
    } slot_e;

    typedef struct packed {
        logic        en;
        logic [10:0] rsvd;
        logic [3:0]  code;
    } ctl_t;

    function automatic logic src_eval(input logic [3:0] code,
                                      input logic [NUM_SHARED-1:0] sh,
                                      input logic [NUM_IND-1:0] ind);
        logic r;
        case (code)
            SRC_ALWAYS: r = 1'b1;
            SRC_SH0:    r = sh[0];
            SRC_SH1:    r = sh[1];
            SRC_SH2:    r = sh[2];
            SRC_SH3:    r = sh[3];
            SRC_IND0:   r = ind[0];
            SRC_SH01:   r = sh[0] & sh[1];
            SRC_IND1:   r = ind[1];
            SRC_IND01:  r = ind[0] & ind[1];
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gsc_cond_sel.sv
module gsc_cond_sel
    import gsc_pkg::*;
(
    input  logic                  en,
    input  logic [3:0]            code,
    input  logic [NUM_SHARED-1:0] sh,
    input  logic [NUM_IND-1:0]    ind,
    output logic                  fire
);
    always_comb begin
        fire = en && src_eval(code, sh, ind);
    end
endmodule

// File: rtl/gsc_channel.sv
module gsc_channel
    import gsc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  gate_we,
    input  logic                  load_we,
    input  logic                  pre_we,
    input  logic                  clr_we,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [NUM_SHARED-1:0] sh,
    input  logic [NUM_IND-1:0]    ind,
    output ctl_t                  gate_ctl,
    output ctl_t                  load_ctl,
    output logic [CNT_W-1:0]      preset,
    output logic [CNT_W-1:0]      count,
    output logic                  ovf,
    output logic                  gate_fire,
    output logic                  load_fire
);
    logic wrap;

    gsc_cond_sel u_gate_sel (
        .en   (gate_ctl.en),
        .code (gate_ctl.code),
        .sh   (sh),
        .ind  (ind),
        .fire (gate_fire)
    );

    gsc_cond_sel u_load_sel (
        .en   (load_ctl.en),
        .code (load_ctl.code),
        .sh   (sh),
        .ind  (ind),
        .fire (load_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_ctl <= '0;
            load_ctl <= '0;
            preset   <= '0;
        end else begin
            if (gate_we) gate_ctl <= ctl_t'(wr_data[CTL_W-1:0]);
            if (load_we) load_ctl <= ctl_t'(wr_data[CTL_W-1:0]);
            if (pre_we)  preset   <= wr_data;
        end
    end

    // load takes priority over an increment on the same edge
    assign wrap = gate_fire && !load_fire && (&count);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_fire) begin
            count <= preset;
        end else if (gate_fire) begin
            count <= count + 1'b1;
        end
    end

    // a wrap on the same edge as a clearing write leaves the flag set
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (wrap) begin
            ovf <= 1'b1;
        end else if (clr_we) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/gated_scaler_bank.sv
module gated_scaler_bank
    import gsc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + SLOT_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CNT_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [CNT_W-1:0]            rd_data,
    input  logic [NUM_SHARED-1:0]       shared_ctl,
    input  logic [NUM_CH*NUM_IND-1:0]   ind_ctl,
    input  logic                        latch
);
    ctl_t             gate_ctl_a  [NUM_CH];
    ctl_t             load_ctl_a  [NUM_CH];
    logic [CNT_W-1:0] preset_a    [NUM_CH];
    logic [CNT_W-1:0] cnt_a       [NUM_CH];
    logic [CNT_W-1:0] snap_a      [NUM_CH];
    logic             ovf_a       [NUM_CH];
    logic             gate_fire_a [NUM_CH];
    logic             load_fire_a [NUM_CH];

    logic [CH_W-1:0] wr_ch, rd_ch;
    slot_e           wr_slot, rd_slot;

    assign wr_ch   = wr_addr[ADDR_W-1:SLOT_W];
    assign wr_slot = slot_e'(wr_addr[SLOT_W-1:0]);
    assign rd_ch   = rd_addr[ADDR_W-1:SLOT_W];
    assign rd_slot = slot_e'(rd_addr[SLOT_W-1:0]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == CH_W'(i));

        gsc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .gate_we   (hit && wr_slot == SLOT_GATE),
            .load_we   (hit && wr_slot == SLOT_LOAD),
            .pre_we    (hit && wr_slot == SLOT_PRESET),
            .clr_we    (hit && wr_slot == SLOT_STATUS),
            .wr_data   (wr_data),
            .sh        (shared_ctl),
            .ind       (ind_ctl[i*NUM_IND +: NUM_IND]),
            .gate_ctl  (gate_ctl_a[i]),
            .load_ctl  (load_ctl_a[i]),
            .preset    (preset_a[i]),
            .count     (cnt_a[i]),
            .ovf       (ovf_a[i]),
            .gate_fire (gate_fire_a[i]),
            .load_fire (load_fire_a[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                snap_a[i] <= '0;
            end else if (latch) begin
                snap_a[i] <= cnt_a[i];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_ch) < NUM_CH) begin
            case (rd_slot)
                SLOT_GATE:   rd_data = CNT_W'(gate_ctl_a[rd_ch]);
                SLOT_LOAD:   rd_data = CNT_W'(load_ctl_a[rd_ch]);
                SLOT_PRESET: rd_data = preset_a[rd_ch];
                SLOT_STATUS: rd_data = CNT_W'(ovf_a[rd_ch]);
                SLOT_SNAP:   rd_data = snap_a[rd_ch];
                default:     rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/gsc_checker.sv
module gsc_checker
    import gsc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + SLOT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              latch,
    input ctl_t              gate_ctl_a  [NUM_CH],
    input ctl_t              load_ctl_a  [NUM_CH],
    input logic [CNT_W-1:0]  preset_a    [NUM_CH],
    input logic [CNT_W-1:0]  cnt_a       [NUM_CH],
    input logic [CNT_W-1:0]  snap_a      [NUM_CH],
    input logic              ovf_a       [NUM_CH],
    input logic              load_fire_a [NUM_CH]
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        logic clr_hit;
        assign clr_hit = wr_en && (wr_addr == {CH_W'(i), SLOT_STATUS});

        AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!gate_ctl_a[i].en && !load_ctl_a[i].en) |=> $stable(cnt_a[i])); // R2
        AST_ALWAYS_COUNTS: assert property (@(posedge clk) disable iff (rst)
            (gate_ctl_a[i] == 16'h8000 && !load_ctl_a[i].en)
            |=> cnt_a[i] == $past(cnt_a[i]) + 1'b1); // R3
        AST_LOAD_TAKES_PRESET: assert property (@(posedge clk) disable iff (rst)
            load_fire_a[i] |=> cnt_a[i] == $past(preset_a[i])); // R7
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (ovf_a[i] && !clr_hit) |=> ovf_a[i]); // R8
        AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !latch |=> $stable(snap_a[i])); // R9
        AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            latch |=> snap_a[i] == $past(cnt_a[i])); // R9
    end
endmodule

bind gated_scaler_bank gsc_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .latch       (latch),
    .gate_ctl_a  (gate_ctl_a),
    .load_ctl_a  (load_ctl_a),
    .preset_a    (preset_a),
    .cnt_a       (cnt_a),
    .snap_a      (snap_a),
    .ovf_a       (ovf_a),
    .load_fire_a (load_fire_a)
);

// File: tb/gated_scaler_bank_test.sv
module gated_scaler_bank_test;
    localparam int  NCH = 4;
    localparam int  CW  = 32;
    localparam int  AW  = 5;
    localparam time CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic [3:0]    shared_ctl = '0;
    logic [2*NCH-1:0] ind_ctl = '0;
    logic          latch = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    gated_scaler_bank #(.NUM_CH(NCH), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .shared_ctl(shared_ctl),
        .ind_ctl(ind_ctl), .latch(latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // expected-state model written from the requirements
    logic [15:0] m_g [NCH];
    logic [15:0] m_l [NCH];
    logic [31:0] m_p [NCH];
    logic [31:0] m_c [NCH];
    logic [31:0] m_s [NCH];
    logic        m_o [NCH];

    function automatic bit src(input logic [15:0] c, input logic [3:0] sh, input logic [1:0] id);
        if (!c[15]) return 1'b0;
        case (c[3:0])
            4'd0:  return 1'b1;
            4'd1:  return sh[0];
            4'd2:  return sh[1];
            4'd3:  return sh[2];
            4'd4:  return sh[3];
            4'd8:  return id[0];
            4'd9:  return sh[0] & sh[1];
            4'd10: return id[1];
            4'd11: return id[0] & id[1];
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        for (int ch = 0; ch < NCH; ch++) begin
            if (rst) begin
                m_g[ch] <= '0; m_l[ch] <= '0; m_p[ch] <= '0;
                m_c[ch] <= '0; m_s[ch] <= '0; m_o[ch] <= 1'b0;
            end else begin
                bit lf, gf, wch, clr;
                lf  = src(m_l[ch], shared_ctl, ind_ctl[2*ch +: 2]);
                gf  = src(m_g[ch], shared_ctl, ind_ctl[2*ch +: 2]);
                wch = wr_en && (int'(wr_addr[4:3]) == ch);
                clr = wch && wr_addr[2:0] == 3'd3;
                if (lf) m_c[ch] <= m_p[ch];
                else if (gf) m_c[ch] <= m_c[ch] + 1;
                if (!lf && gf && m_c[ch] == 32'hFFFF_FFFF) m_o[ch] <= 1'b1;
                else if (clr) m_o[ch] <= 1'b0;
                if (latch) m_s[ch] <= m_c[ch];
                if (wch && wr_addr[2:0] == 3'd0) m_g[ch] <= wr_data[15:0];
                if (wch && wr_addr[2:0] == 3'd1) m_l[ch] <= wr_data[15:0];
                if (wch && wr_addr[2:0] == 3'd2) m_p[ch] <= wr_data;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input int ch, input int slot, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_addr = AW'({ch[1:0], slot[2:0]});
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wr(input int ch, input int slot, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'({ch[1:0], slot[2:0]}); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input logic [3:0] shm, input logic [7:0] indm);
        repeat (n) begin
            @(negedge clk);
            shared_ctl = 4'($urandom) & shm;
            ind_ctl    = 8'($urandom) & indm;
        end
        @(negedge clk);
        shared_ctl = '0; ind_ctl = '0;
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        latch = 1'b1;
        @(negedge clk);
        latch = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            rd_chk(ch, 4, m_s[ch], tag);
            rd_chk(ch, 3, {31'd0, m_o[ch]}, tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int ch = 0; ch < NCH; ch++)
            for (int s = 0; s < 5; s++) rd_chk(ch, s, 32'd0, "R1");

        // R10 register readback
        wr(1, 0, 32'hFFFF_8003);
        wr(1, 1, 32'h0000_0008);
        wr(1, 2, 32'h1234_5678);
        rd_chk(1, 0, 32'h0000_8003, "R10");
        rd_chk(1, 1, 32'h0000_0008, "R10");
        rd_chk(1, 2, 32'h1234_5678, "R10");
        wr(1, 0, 32'h0);

        // R3 always-on gate
        wr(0, 0, 32'h8000);
        run(25, 4'h0, 8'h00);
        check_all("R3");

        // R2 disabled words ignore active lines
        wr(2, 0, 32'h0001);
        wr(2, 1, 32'h0008);
        run(20, 4'hF, 8'hFF);
        check_all("R2");
        rd_chk(2, 4, 32'd0, "R2");

        // R4 single shared line
        wr(3, 0, 32'h8003);
        run(60, 4'hF, 8'h00);
        check_all("R4");

        // R5 coincidences
        wr(3, 0, 32'h8009);
        run(60, 4'hF, 8'hFF);
        check_all("R5");
        wr(3, 0, 32'h800B);
        run(60, 4'hF, 8'hFF);
        check_all("R5");

        // R6 per-channel lines are private
        wr(1, 1, 32'h0);
        wr(1, 0, 32'h800A);
        check_all("R6");
        run(40, 4'hF, 8'hF3);
        check_all("R6");
        run(40, 4'h0, 8'h0C);
        check_all("R6");

        // R7 load priority, ticks since last strobe
        wr(0, 2, 32'h0);
        wr(0, 1, 32'h8008);
        run(50, 4'h0, 8'h01);
        check_all("R7");
        @(negedge clk); ind_ctl = 8'h01;
        @(negedge clk); ind_ctl = 8'h00;
        repeat (6) @(negedge clk);
        latch = 1'b1;
        @(negedge clk); latch = 1'b0;
        rd_chk(0, 4, 32'd6, "R7");

        // R8 wrap and sticky flag
        wr(2, 0, 32'h0);
        wr(2, 2, 32'hFFFF_FFFD);
        wr(2, 1, 32'h8008);
        @(negedge clk); ind_ctl = 8'h10;
        @(negedge clk); ind_ctl = 8'h00;
        wr(2, 1, 32'h0);
        wr(2, 0, 32'h8000);
        repeat (4) @(negedge clk);
        check_all("R8");
        rd_chk(2, 3, 32'd1, "R8");
        wr(2, 0, 32'h0);
        rd_chk(2, 3, 32'd1, "R8");
        wr(2, 3, 32'h0);
        rd_chk(2, 3, 32'd0, "R8");

        // R9 snapshot holds while counters move
        wr(3, 0, 32'h8000);
        check_all("R9");
        begin
            logic [31:0] held;
            held = m_s[3];
            run(10, 4'h0, 8'h00);
            rd_chk(3, 4, held, "R9");
        end

        // R11 unused codes
        wr(3, 0, 32'h8005);
        check_all("R11");
        run(20, 4'hF, 8'hFF);
        check_all("R11");
        wr(3, 0, 32'h800C);
        run(20, 4'hF, 8'hFF);
        check_all("R11");

        // random rounds
        for (int r = 0; r < 8; r++) begin
            for (int ch = 0; ch < NCH; ch++) begin
                wr(ch, 0, {16'd0, 1'($urandom), 11'd0, 4'($urandom)});
                wr(ch, 1, {16'd0, ($urandom % 4 == 0) ? 1'b1 : 1'b0, 11'd0, 4'($urandom)});
                wr(ch, 2, ($urandom % 2) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom);
            end
            run(150, 4'hF, 8'hFF);
            check_all("R4");
            if (r % 3 == 0) wr(r % NCH, 3, 32'h0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule